// File: doc/BRIEF.md
# DMA Channel Address and Loop Engine

This block is the data-movement core of one DMA channel. A transfer descriptor held on its configuration inputs sets the start addresses, the signed per-beat offsets, the access size and circular-buffer width of each side, the bytes moved per activation (the minor loop), and the signed adjustments applied when the whole transfer (the major loop) ends. Each `start` pulse runs one minor loop. The minor loop is a series of beats, and each beat is a read followed by a write on a single-outstanding memory port. At the end of the minor loop the engine applies any minor-loop offset and counts the iteration down. When the count runs out it applies the end adjustments and reloads the count.

The controller is a five-state machine. `ST_IDLE` waits and leaves on `start`. `ST_CHECK` vets the next beat: it returns to `ST_IDLE` with the error flag set if the beat is illegal, and otherwise goes to `ST_READ`. `ST_READ` holds a read request until `mem_ready` and then goes to `ST_WRITE`. `ST_WRITE` holds a write request until `mem_ready`. It then goes back to `ST_CHECK` while bytes remain, or to `ST_LOOP` when none remain. `ST_LOOP` lasts one cycle: it updates the counter, flags and addresses, then returns to `ST_IDLE`.

Top module: `dma_loop_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `err`, `half_flag`, `major_flag` and `irq` are 0, and `src_addr`, `dst_addr` and `citer` are 0.
- R2: A `desc_load` pulse while idle copies `src_init` to `src_addr`, `dst_init` to `dst_addr` and `begin_cnt` to `citer`.
- R3: The low 3 bits of `src_attr` and `dst_attr` code the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. A minor loop of N bytes runs N/size beats. Each beat puts the size code on `mem_size`.
- R4: After each beat, `src_addr` moves by the signed 16-bit `src_off` and `dst_addr` moves by the signed `dst_off`. An offset of zero leaves the address fixed.
- R5: Bits [7:3] of an attribute form a modulo width k. When k is nonzero, every address update changes only the low k address bits, which wrap inside an aligned 2^k-byte window.
- R6: With `minor_map_en` set, `nbytes_cfg[9:0]` is the byte count, bit 31 enables a source offset, bit 30 enables a destination offset, and bits [29:10] hold a signed offset. After each minor loop this offset is added to every enabled address.
- R7: Each completed minor loop decrements `citer`. When the count was 1, the major loop completes: `citer` reloads from `begin_cnt` and `src_last` is added to `src_addr`.
- R8: At major completion `dst_last` is added to `dst_addr` when `sg_en` is 0. When `sg_en` is 1, `dst_addr` receives no adjustment.
- R9: With `link_en` set, only `citer[8:0]` counts, `citer[14:9]` is preserved, and the half and zero tests use the low 9 bits of both counters.
- R10: `half_flag` sets when the decremented count equals the beginning count shifted right by one. `major_flag` sets at major completion. `irq` is the OR of each flag ANDed with its enable (`half_ie`, `major_ie`). `flag_clr` clears both flags and `err`.
- R11: A beat is illegal if source and destination sizes differ, the size code is above 2, either address is misaligned for the size, or the remaining byte count is zero or not a multiple of the size. An illegal beat sets `err` and ends the minor loop without issuing that beat, and `citer` is left unchanged.
- R12: Only one request is outstanding at a time. A request holds its address and direction until `mem_ready`. A write is issued only after its read completes, and it carries the read data masked to the access size.
- R13: `busy` is high from the cycle after an accepted `start` until the engine returns to idle. A `start` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Load start addresses and count (accepted while idle) |
| start | input | 1 | Run one minor loop (accepted while idle) |
| flag_clr | input | 1 | Clear error, half and major flags |
| src_init | input | AW | Source start address |
| dst_init | input | AW | Destination start address |
| src_off | input | 16 | Signed per-beat source offset |
| dst_off | input | 16 | Signed per-beat destination offset |
| src_attr | input | 8 | Source modulo width [7:3], size code [2:0] |
| dst_attr | input | 8 | Destination modulo width [7:3], size code [2:0] |
| nbytes_cfg | input | 32 | Minor-loop byte count, or mapped word when `minor_map_en` |
| minor_map_en | input | 1 | Interpret `nbytes_cfg` as flags, offset and count |
| src_last | input | AW | Signed source adjustment at major completion |
| dst_last | input | AW | Signed destination adjustment at major completion |
| sg_en | input | 1 | Suppress the destination end adjustment |
| link_en | input | 1 | Counter uses low 9 bits only |
| begin_cnt | input | CW | Beginning iteration count |
| half_ie | input | 1 | Enable `irq` from the half flag |
| major_ie | input | 1 | Enable `irq` from the major flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data, right-justified |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | DW | Read data, right-justified, valid with `mem_ready` |
| busy | output | 1 | Minor loop in progress |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| citer | output | CW | Current iteration count |
| half_flag | output | 1 | Half-complete flag (sticky) |
| major_flag | output | 1 | Major-complete flag (sticky) |
| irq | output | 1 | Interrupt request |
| err | output | 1 | Error flag (sticky) |

## Verification
`busy` rises on the clock edge after `start` is sampled. Each beat then takes one check cycle plus the memory latency of the read and of the write. The loop update follows the last write in one more cycle, so addresses, count and flags hold their final values on the cycle when `busy` falls. The bench therefore waits on `busy` rather than counting cycles, samples one falling edge later, and compares against its reference model. Write beats are pushed into an expected queue as the model predicts them. A monitor pops each entry at the falling edge of the cycle in which a write meets `mem_ready`. A write that arrives with the queue empty, or an entry left over after the engine goes idle, is reported as a failure.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_LOOP
    } eng_state_e;

    // Field layout of the mapped byte-count word
    localparam int MAP_SRC_EN_BIT = 31;
    localparam int MAP_DST_EN_BIT = 30;
    localparam int MLOFF_LSB      = 10;
    localparam int MLOFF_W        = 20;
    localparam int MAP_CNT_W      = 10;

    // Attribute layout: modulo width above the size code
    localparam int SIZE_CODE_W    = 3;
    localparam int MOD_W          = 5;

    function automatic logic [5:0] size_bytes(input logic [SIZE_CODE_W-1:0] code);
        case (code)
            3'd0:    size_bytes = 6'd1;
            3'd1:    size_bytes = 6'd2;
            3'd2:    size_bytes = 6'd4;
            default: size_bytes = 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] init,
    input  logic          step,
    input  logic [AW-1:0] delta,
    input  logic [4:0]    mod_k,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] low_mask;
    logic [AW-1:0] sum;
    logic [AW-1:0] nxt;

    always_comb begin
        low_mask = (mod_k == 5'd0) ? '1 : ((AW'(1) << mod_k) - AW'(1));
        sum      = addr + delta;
        nxt      = (addr & ~low_mask) | (sum & low_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= init;
        else if (step) addr <= nxt;
    end

    // R4: a zero offset leaves the address fixed
    p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && delta == '0) |=> addr == $past(addr));

    // R5: the bits above the modulo window never move during a step
    p_modulo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mod_k != 5'd0) |=>
        ((addr & ~$past(low_mask)) == ($past(addr) & ~$past(low_mask))));

endmodule

// File: rtl/dma_iter_ctr.sv
module dma_iter_ctr #(
    parameter int CW = 15,
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] begin_cnt,
    input  logic          link_en,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          done_hit,
    output logic          half_hit
);

    localparam logic [CW-1:0] LINK_MASK = CW'((1 << LW) - 1);

    logic [CW-1:0] eff, beg_eff, nxt_eff, nxt_cnt;
    logic          last;

    always_comb begin
        eff      = link_en ? (cnt & LINK_MASK)       : cnt;
        beg_eff  = link_en ? (begin_cnt & LINK_MASK) : begin_cnt;
        nxt_eff  = eff - CW'(1);
        last     = (eff <= CW'(1));
        done_hit = dec && last;
        half_hit = dec && (nxt_eff == (beg_eff >> 1));
        if (last)         nxt_cnt = begin_cnt;
        else if (link_en) nxt_cnt = (cnt & ~LINK_MASK) | (nxt_eff & LINK_MASK);
        else              nxt_cnt = nxt_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= begin_cnt;
        else if (dec)  cnt <= nxt_cnt;
    end

    // R7: the last iteration reloads the beginning count
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && eff <= CW'(1)) |=> cnt == $past(begin_cnt));

    // R9: link bits above the counting field survive a decrement
    p_link_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && link_en && eff > CW'(1)) |=> cnt[CW-1:LW] == $past(cnt[CW-1:LW]));

endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
    import dma_eng_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 15,
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_load,
    input  logic          start,
    input  logic          flag_clr,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic [15:0]   src_off,
    input  logic [15:0]   dst_off,
    input  logic [7:0]    src_attr,
    input  logic [7:0]    dst_attr,
    input  logic [31:0]   nbytes_cfg,
    input  logic          minor_map_en,
    input  logic [AW-1:0] src_last,
    input  logic [AW-1:0] dst_last,
    input  logic          sg_en,
    input  logic          link_en,
    input  logic [CW-1:0] begin_cnt,
    input  logic          half_ie,
    input  logic          major_ie,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] citer,
    output logic          half_flag,
    output logic          major_flag,
    output logic          irq,
    output logic          err
);

    localparam int NB_W  = 32;
    localparam int OFF_W = 16;

    eng_state_e st_q, st_d;

    logic [NB_W-1:0] rem_q, rem_left, min_cnt;
    logic [DW-1:0]   data_q, size_mask;
    logic            err_q, half_q, major_q;

    logic [SIZE_CODE_W-1:0] src_sz, dst_sz;
    logic [5:0]             beat_n;
    logic [AW-1:0]          align, src_sext, dst_sext, mloff, src_delta, dst_delta;
    logic [MLOFF_W-1:0]     mloff_raw;
    logic                   beat_bad, rd_done, wr_done, loop_step, is_idle, load_ok;
    logic                   src_step, dst_step, major_now, half_now;

    // ---------------- decode ----------------
    always_comb begin
        src_sz    = src_attr[SIZE_CODE_W-1:0];
        dst_sz    = dst_attr[SIZE_CODE_W-1:0];
        beat_n    = size_bytes(src_sz);
        align     = AW'(beat_n) - AW'(1);
        size_mask = (beat_n >= 6'd4) ? '1 : ((DW'(1) << {beat_n, 3'b000}) - DW'(1));
        min_cnt   = minor_map_en ? NB_W'(nbytes_cfg[MAP_CNT_W-1:0]) : nbytes_cfg;
        rem_left  = rem_q - NB_W'(beat_n);
        beat_bad  = (src_sz != dst_sz) || (beat_n == 6'd0)
                  || ((src_addr & align) != '0) || ((dst_addr & align) != '0)
                  || ((rem_q & NB_W'(beat_n - 6'd1)) != '0) || (rem_q == '0);
        is_idle   = (st_q == ST_IDLE);
        load_ok   = desc_load && is_idle;
        rd_done   = (st_q == ST_READ)  && mem_ready;
        wr_done   = (st_q == ST_WRITE) && mem_ready;
        loop_step = (st_q == ST_LOOP);
    end

    // ---------------- address deltas ----------------
    always_comb begin
        mloff_raw = nbytes_cfg[MLOFF_LSB +: MLOFF_W];
        mloff     = {{(AW-MLOFF_W){mloff_raw[MLOFF_W-1]}}, mloff_raw};
        src_sext  = {{(AW-OFF_W){src_off[OFF_W-1]}}, src_off};
        dst_sext  = {{(AW-OFF_W){dst_off[OFF_W-1]}}, dst_off};
        if (loop_step) begin
            src_delta = ((minor_map_en && nbytes_cfg[MAP_SRC_EN_BIT]) ? mloff : '0)
                      + (major_now ? src_last : '0);
            dst_delta = ((minor_map_en && nbytes_cfg[MAP_DST_EN_BIT]) ? mloff : '0)
                      + ((major_now && !sg_en) ? dst_last : '0);
        end else begin
            src_delta = src_sext;
            dst_delta = dst_sext;
        end
        src_step = rd_done || loop_step;
        dst_step = wr_done || loop_step;
    end

    // Generated pair of address units: index 0 is the source side, index 1 the destination
    logic [AW-1:0] side_init  [2];
    logic          side_step  [2];
    logic [AW-1:0] side_delta [2];
    logic [4:0]    side_mod   [2];
    logic [AW-1:0] side_addr  [2];

    always_comb begin
        side_init[0]  = src_init;   side_init[1]  = dst_init;
        side_step[0]  = src_step;   side_step[1]  = dst_step;
        side_delta[0] = src_delta;  side_delta[1] = dst_delta;
        side_mod[0]   = src_attr[SIZE_CODE_W +: MOD_W];
        side_mod[1]   = dst_attr[SIZE_CODE_W +: MOD_W];
    end

    for (genvar g = 0; g < 2; g++) begin : g_side
        dma_addr_unit #(.AW(AW)) u_addr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_ok),
            .init  (side_init[g]),
            .step  (side_step[g]),
            .delta (side_delta[g]),
            .mod_k (side_mod[g]),
            .addr  (side_addr[g])
        );
    end

    assign src_addr = side_addr[0];
    assign dst_addr = side_addr[1];

    dma_iter_ctr #(.CW(CW), .LW(LW)) u_iter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ok),
        .begin_cnt (begin_cnt),
        .link_en   (link_en),
        .dec       (loop_step),
        .cnt       (citer),
        .done_hit  (major_now),
        .half_hit  (half_now)
    );

    // ---------------- state machine ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start)     st_d = ST_CHECK;
            ST_CHECK: st_d = beat_bad ? ST_IDLE : ST_READ;
            ST_READ:  if (mem_ready) st_d = ST_WRITE;
            ST_WRITE: if (mem_ready) st_d = (rem_left == '0) ? ST_LOOP : ST_CHECK;
            ST_LOOP:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- datapath and flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
            half_q  <= 1'b0;
            major_q <= 1'b0;
        end else begin
            if (is_idle && start) rem_q <= min_cnt;
            else if (wr_done)     rem_q <= rem_left;
            if (rd_done) data_q <= mem_rdata & size_mask;
            if ((st_q == ST_CHECK) && beat_bad) err_q <= 1'b1;
            else if (flag_clr)                  err_q <= 1'b0;
            if (half_now)      half_q <= 1'b1;
            else if (flag_clr) half_q <= 1'b0;
            if (major_now)     major_q <= 1'b1;
            else if (flag_clr) major_q <= 1'b0;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_req    = (st_q == ST_READ) || (st_q == ST_WRITE);
        mem_we     = (st_q == ST_WRITE);
        mem_addr   = (st_q == ST_WRITE) ? dst_addr : src_addr;
        mem_size   = src_sz[1:0];
        mem_wdata  = data_q;
        busy       = !is_idle;
        err        = err_q;
        half_flag  = half_q;
        major_flag = major_q;
        irq        = (half_q && half_ie) || (major_q && major_ie);
    end

    // R12: a pending request holds its address and direction
    p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12: a completed read is followed straight away by its write
    p_read_then_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    // R11: raising the error flag never coincides with a request
    p_err_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !mem_req);

    // R13: an accepted start makes the engine busy on the next cycle
    p_busy_after_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: tb/dma_loop_engine_tb.sv
module dma_loop_engine_tb;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_load = 1'b0, start = 1'b0, flag_clr = 1'b0;
    logic [AW-1:0] src_init = '0, dst_init = '0, src_last = '0, dst_last = '0;
    logic [15:0]   src_off = '0, dst_off = '0;
    logic [7:0]    src_attr = '0, dst_attr = '0;
    logic [31:0]   nbytes_cfg = '0;
    logic          minor_map_en = 1'b0, sg_en = 1'b0, link_en = 1'b0;
    logic [CW-1:0] begin_cnt = '0;
    logic          half_ie = 1'b0, major_ie = 1'b0;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          busy, half_flag, major_flag, irq, err;
    logic [AW-1:0] src_addr, dst_addr;
    logic [CW-1:0] citer;

    always #5 clk = ~clk;

    dma_loop_engine u_dut (
        .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .start(start), .flag_clr(flag_clr),
        .src_init(src_init), .dst_init(dst_init), .src_off(src_off), .dst_off(dst_off),
        .src_attr(src_attr), .dst_attr(dst_attr), .nbytes_cfg(nbytes_cfg),
        .minor_map_en(minor_map_en), .src_last(src_last), .dst_last(dst_last),
        .sg_en(sg_en), .link_en(link_en), .begin_cnt(begin_cnt),
        .half_ie(half_ie), .major_ie(major_ie),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .src_addr(src_addr), .dst_addr(dst_addr), .citer(citer),
        .half_flag(half_flag), .major_flag(major_flag), .irq(irq), .err(err)
    );

    // ---------------- memory model: one wait cycle per access ----------------
    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_ready <= 1'b0;
        else        mem_ready <= mem_req && !mem_ready;
    end

    always_ff @(posedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ready) begin
            for (int i = 0; i < (1 << mem_size); i++)
                mem[8'(mem_addr[7:0] + 8'(i))] <= mem_wdata[8*i +: 8];
        end
    end

    always_comb begin
        mem_rdata = {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                     mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
    } wr_t;
    wr_t exp_q[$];

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ready) begin
            if (exp_q.size() == 0) begin
                chk("R11/R12 unexpected write", {32'd0, mem_addr}, 64'hFFFF_FFFF);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk("R12 write addr/data", {mem_addr, mem_wdata}, {e.addr, e.data});
                chk("R3 write size", {62'd0, mem_size}, {62'd0, e.size});
            end
        end
    end

    // ---------------- reference model ----------------
    logic [31:0]   m_src, m_dst;
    logic [CW-1:0] m_cnt;
    logic          m_half, m_major, m_err;

    function automatic logic [31:0] f_step(input logic [31:0] a, input logic [31:0] d,
                                           input logic [4:0] k);
        logic [31:0] msk;
        msk = (k == 5'd0) ? 32'hFFFF_FFFF : ((32'd1 << k) - 32'd1);
        return (a & ~msk) | ((a + d) & msk);
    endfunction

    task automatic run_model();
        logic [31:0] rem, n, data, mloff, ds_d, dd_d;
        logic [2:0]  ss, dz;
        logic [CW-1:0] eff, beg, nx;
        logic        major;
        ss  = src_attr[2:0];
        dz  = dst_attr[2:0];
        rem = minor_map_en ? {22'd0, nbytes_cfg[9:0]} : nbytes_cfg;
        while (1) begin
            n = (ss == 3'd0) ? 1 : (ss == 3'd1) ? 2 : (ss == 3'd2) ? 4 : 0;
            if (ss != dz || n == 0 || rem == 0 || (rem % n) != 0 ||
                (m_src % n) != 0 || (m_dst % n) != 0) begin
                m_err = 1'b1;
                return;
            end
            data = '0;
            for (int i = 0; i < n; i++) data[8*i +: 8] = ref_mem[8'(m_src[7:0] + 8'(i))];
            exp_q.push_back('{addr: m_dst, size: ss[1:0], data: data});
            for (int i = 0; i < n; i++) ref_mem[8'(m_dst[7:0] + 8'(i))] = data[8*i +: 8];
            m_src = f_step(m_src, {{16{src_off[15]}}, src_off}, src_attr[7:3]);
            m_dst = f_step(m_dst, {{16{dst_off[15]}}, dst_off}, dst_attr[7:3]);
            rem   = rem - n;
            if (rem == 0) break;
        end
        eff = link_en ? {6'd0, m_cnt[8:0]} : m_cnt;
        beg = link_en ? {6'd0, begin_cnt[8:0]} : begin_cnt;
        nx  = eff - 15'd1;
        if (nx == (beg >> 1)) m_half = 1'b1;
        major = (eff <= 15'd1);
        if (major) begin
            m_major = 1'b1;
            m_cnt   = begin_cnt;
        end else begin
            m_cnt = link_en ? {m_cnt[14:9], nx[8:0]} : nx;
        end
        mloff = {{12{nbytes_cfg[29]}}, nbytes_cfg[29:10]};
        ds_d  = ((minor_map_en && nbytes_cfg[31]) ? mloff : 32'd0) + (major ? src_last : 32'd0);
        dd_d  = ((minor_map_en && nbytes_cfg[30]) ? mloff : 32'd0) +
                ((major && !sg_en) ? dst_last : 32'd0);
        m_src = f_step(m_src, ds_d, src_attr[7:3]);
        m_dst = f_step(m_dst, dd_d, dst_attr[7:3]);
    endtask

    // ---------------- driver tasks ----------------
    task automatic load_desc(input logic [31:0] s, input logic [31:0] d, input logic [CW-1:0] b);
        src_init = s; dst_init = d; begin_cnt = b;
        desc_load = 1'b1;
        @(negedge clk);
        desc_load = 1'b0;
        m_src = s; m_dst = d; m_cnt = b;
        chk("R2 load src", {32'd0, src_addr}, {32'd0, s});
        chk("R2 load dst", {32'd0, dst_addr}, {32'd0, d});
        chk("R2 load count", {49'd0, citer}, {49'd0, b});
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_half = 1'b0; m_major = 1'b0; m_err = 1'b0;
        chk("R10 flags cleared", {61'd0, err, half_flag, major_flag}, 64'd0);
    endtask

    task automatic activate(input string tag, input bit extra_start);
        int t;
        run_model();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R13 busy"}, {63'd0, busy}, 64'd1);
        t = 0;
        while (busy && t < 2000) begin
            @(negedge clk);
            t++;
            if (extra_start && t == 2) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        if (t >= 2000) chk({tag, " R13 timeout"}, 64'd1, 64'd0);
        @(negedge clk);
        chk({tag, " R13 idle"}, {63'd0, busy}, 64'd0);
        chk({tag, " R4 src addr"}, {32'd0, src_addr}, {32'd0, m_src});
        chk({tag, " R4 dst addr"}, {32'd0, dst_addr}, {32'd0, m_dst});
        chk({tag, " R7 count"}, {49'd0, citer}, {49'd0, m_cnt});
        chk({tag, " R10 flags"}, {60'd0, err, half_flag, major_flag, irq},
            {60'd0, m_err, m_half, m_major, (m_half & half_ie) | (m_major & major_ie)});
        chk({tag, " R12 queue drained"}, 64'(exp_q.size()), 64'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R13 act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
        m_half = 1'b0; m_major = 1'b0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {57'd0, busy, mem_req, err, half_flag, major_flag, irq, 1'b0},
            64'd0);
        chk("R1 reset regs", {src_addr, dst_addr}, 64'd0);
        chk("R1 reset count", {49'd0, citer}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R7 R8 R10: 32-bit linear buffers, two beats per minor loop, four iterations
        src_attr = 8'd2; dst_attr = 8'd2; src_off = 16'd4; dst_off = 16'd4;
        nbytes_cfg = 32'd8; src_last = -32'sd32; dst_last = -32'sd32;
        major_ie = 1'b1;
        load_desc(32'h10, 32'h80, 15'd4);
        for (int k = 0; k < 4; k++) activate("R3 word buffer", 1'b0);
        chk("R8 dst back to start", {32'd0, dst_addr}, 64'h80);
        chk("R10 irq on major", {63'd0, irq}, 64'd1);
        clear_flags();

        // R4 R13: byte source to fixed register, extra start ignored while busy
        src_attr = 8'd0; dst_attr = 8'd0; src_off = 16'd1; dst_off = 16'd0;
        nbytes_cfg = 32'd3; src_last = 32'd0; dst_last = 32'd0; half_ie = 1'b1;
        load_desc(32'h20, 32'hE0, 15'd2);
        activate("R13 start while busy", 1'b1);
        chk("R4 fixed dst", {32'd0, dst_addr}, 64'hE0);
        activate("R4 peripheral", 1'b0);
        clear_flags();

        // R5: destination ring of 8 bytes at 0x90
        dst_attr = {5'd3, 3'd0}; dst_off = 16'd1; nbytes_cfg = 32'd4; half_ie = 1'b0;
        load_desc(32'h20, 32'h90, 15'd4);
        activate("R5 ring first", 1'b0);
        activate("R5 ring wrap", 1'b0);
        chk("R5 dst wrapped", {32'd0, dst_addr}, 64'h90);
        clear_flags();

        // R6: mapped count, 16-bit beats, source pulled back by 4 after each minor loop
        src_attr = 8'd1; dst_attr = 8'd1; src_off = 16'd2; dst_off = 16'd2;
        minor_map_en = 1'b1; nbytes_cfg = {1'b1, 1'b0, 20'hFFFFC, 10'd4};
        src_last = 32'd0; dst_last = -32'sd12;
        load_desc(32'h40, 32'hA0, 15'd3);
        activate("R6 map one", 1'b0);
        chk("R6 src rewound", {32'd0, src_addr}, 64'h40);
        activate("R6 map two", 1'b0);
        activate("R6 map three", 1'b0);
        chk("R6 dst end adjust", {32'd0, dst_addr}, 64'hA0);
        minor_map_en = 1'b0;
        clear_flags();

        // R8: scatter-gather suppresses destination adjustment
        src_attr = 8'd0; dst_attr = 8'd0; src_off = 16'd1; dst_off = 16'd1;
        nbytes_cfg = 32'd2; src_last = -32'sd2; dst_last = -32'sd2; sg_en = 1'b1;
        load_desc(32'h30, 32'hC0, 15'd1);
        activate("R8 sg", 1'b0);
        chk("R8 dst not adjusted", {32'd0, dst_addr}, 64'hC2);
        chk("R7 src adjusted", {32'd0, src_addr}, 64'h30);
        sg_en = 1'b0;
        clear_flags();

        // R9: linked counter keeps upper bits
        link_en = 1'b1; nbytes_cfg = 32'd1; src_last = 32'd0; dst_last = 32'd0;
        load_desc(32'h50, 32'hD0, 15'h5602);
        activate("R9 link one", 1'b0);
        chk("R9 upper kept", {49'd0, citer}, 64'h5601);
        activate("R9 link reload", 1'b0);
        chk("R9 reloaded", {49'd0, citer}, 64'h5602);
        link_en = 1'b0;
        clear_flags();

        // R11: misaligned word source
        src_attr = 8'd2; dst_attr = 8'd2; src_off = 16'd4; dst_off = 16'd4; nbytes_cfg = 32'd4;
        load_desc(32'h12, 32'h80, 15'd5);
        activate("R11 misaligned", 1'b0);
        chk("R11 count unchanged", {49'd0, citer}, 64'd5);
        clear_flags();
        // R11: size mismatch
        dst_attr = 8'd0;
        load_desc(32'h10, 32'h80, 15'd5);
        activate("R11 size mismatch", 1'b0);
        clear_flags();
        // R11: count not a multiple of size
        dst_attr = 8'd2; nbytes_cfg = 32'd6;
        load_desc(32'h10, 32'h80, 15'd5);
        activate("R11 odd count", 1'b0);
        clear_flags();
        // R11: second beat misaligned after one good write
        src_attr = 8'd1; dst_attr = 8'd1; src_off = 16'd3; dst_off = 16'd2; nbytes_cfg = 32'd4;
        load_desc(32'h60, 32'hB0, 15'd5);
        activate("R11 partial abort", 1'b0);
        chk("R11 err raised", {63'd0, err}, 64'd1);
        clear_flags();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule